// File: doc/BRIEF.md
# Lane Vector Register File

This block holds the operand storage of a 16-lane SIMD core whose lanes are 32 bits wide. It contains four fast accumulators, a fifth accumulator that only peripheral results can load, and two banks of 32 registers each. Two write slots, one for the add pipe and one for the multiply pipe, update storage under a per-lane predication mask. Two read ports fetch operands: port 0 reads bank A and port 1 reads bank B, and either port may instead select an accumulator.

The accumulators and the banks have different timing. An accumulator written in a cycle can be read in that same cycle through a bypass, and in every later cycle. A bank write is held in a one-cycle write stage before it reaches the array. A read of the same bank register in the very next cycle therefore returns the old contents and sets a sticky hazard flag. Register indices 32 to 63 do not address storage. They select peripheral registers, and the block passes those reads and writes out on a side-channel.

Top module: `lane_regfile`

## Requirements
- R1: After reset, accumulator codes 0 to 4 read as all zeros and `bank_hazard` is low.
- R2: Lane l occupies bits [l*DW +: DW] of every vector. A write changes only the lanes whose mask bit is 1.
- R3: A slot write to accumulator code 0 to 3 (`*_acc`=1) is visible on a read of that code in the same cycle, and it is held afterwards.
- R4: A bank write (`*_acc`=0, index 0 to 31, `*_bank` 0=A, 1=B) appears on reads issued two or more cycles later. A read in the cycle right after the write returns the previous contents. Port 0 reads bank A and port 1 reads bank B.
- R5: `bank_hazard` rises after the clock edge that ends any cycle in which a read names the same bank and index that a slot wrote in the previous cycle. It stays high until reset. A read of a different index does not set it.
- R6: When both slots target the same accumulator, the same bank register or the same peripheral register in one cycle, the add slot's write takes effect and the multiply slot's write is discarded.
- R7: Accumulator code 4 is loaded only by `r4_load`/`r4_data`, and a read sees the value from the next cycle on. Slot writes with accumulator codes 4 to 7 are ignored. Reads of codes 5 to 7 return zero.
- R8: A read with `*_acc`=0 and index 32 to 63 raises `prdN_req` in the same cycle. The low five index bits appear on `prdN_idx`, and `rdN_data` returns `prdN_data`.
- R9: A slot write with `*_acc`=0 and index 32 to 63 appears in the same cycle on `pwN_*` (slot 0 = add, slot 1 = multiply) with its bank, low five index bits, data and mask. Bank storage is left unchanged.
- R10: A read port whose enable is low outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wa_en | input | 1 | Add-slot write enable |
| wa_acc | input | 1 | Add-slot target is an accumulator |
| wa_bank | input | 1 | Add-slot bank select (0=A, 1=B) |
| wa_idx | input | 6 | Add-slot register index |
| wa_data | input | LANES*DW | Add-slot write vector |
| wa_mask | input | LANES | Add-slot lane mask |
| wm_en | input | 1 | Multiply-slot write enable |
| wm_acc | input | 1 | Multiply-slot target is an accumulator |
| wm_bank | input | 1 | Multiply-slot bank select |
| wm_idx | input | 6 | Multiply-slot register index |
| wm_data | input | LANES*DW | Multiply-slot write vector |
| wm_mask | input | LANES | Multiply-slot lane mask |
| r4_load | input | 1 | Peripheral result load into accumulator code 4 |
| r4_data | input | LANES*DW | Peripheral result vector |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_acc | input | 1 | Read port 0 selects an accumulator |
| rd0_idx | input | 6 | Read port 0 index (bank A or accumulator code) |
| rd0_data | output | LANES*DW | Read port 0 result |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_acc | input | 1 | Read port 1 selects an accumulator |
| rd1_idx | input | 6 | Read port 1 index (bank B or accumulator code) |
| rd1_data | output | LANES*DW | Read port 1 result |
| prd0_req | output | 1 | Peripheral read request from port 0 |
| prd0_idx | output | 5 | Peripheral register number for port 0 |
| prd0_data | input | LANES*DW | Peripheral read data for port 0 |
| prd1_req | output | 1 | Peripheral read request from port 1 |
| prd1_idx | output | 5 | Peripheral register number for port 1 |
| prd1_data | input | LANES*DW | Peripheral read data for port 1 |
| pw0_valid | output | 1 | Add-slot peripheral write valid |
| pw0_bank | output | 1 | Add-slot peripheral write bank |
| pw0_idx | output | 5 | Add-slot peripheral register number |
| pw0_data | output | LANES*DW | Add-slot peripheral write vector |
| pw0_mask | output | LANES | Add-slot peripheral lane mask |
| pw1_valid | output | 1 | Multiply-slot peripheral write valid |
| pw1_bank | output | 1 | Multiply-slot peripheral write bank |
| pw1_idx | output | 5 | Multiply-slot peripheral register number |
| pw1_data | output | LANES*DW | Multiply-slot peripheral write vector |
| pw1_mask | output | LANES | Multiply-slot peripheral lane mask |
| bank_hazard | output | 1 | Sticky flag for a bank read issued right after a write to it |

## Verification
The bench builds the block with LANES=4 and DW=16, so each 64-bit vector is four readable 16-bit lanes and every lane-mask pattern can be written out by hand. NACC stays at 4 and DEPTH at 32. This keeps the real index space: accumulator code 4 for the peripheral-only register, codes 5 to 7 unused, and the split at index 32 between bank storage and peripheral registers. With these values the bench reaches the bypass, the one-cycle stale read and the sticky flag, as well as slot collisions on each kind of target.

// File: rtl/rfv_pkg.sv
package rfv_pkg;

  // Kind of storage a write slot resolves to after decode.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ACC  = 2'd1,
    TGT_BANK = 2'd2,
    TGT_PERI = 2'd3
  } tgt_e;

  localparam int NUM_SLOTS = 2;
  localparam int NUM_BANKS = 2;

endpackage

// File: rtl/rfv_slot_dec.sv
module rfv_slot_dec
  import rfv_pkg::*;
#(
  parameter int IW   = 6,
  parameter int NACC = 4
) (
  input  logic          en,
  input  logic          acc,
  input  logic [IW-1:0] idx,
  output tgt_e          kind
);

  logic acc_ok;

  // Only the slot-writable accumulators qualify; the peripheral-loaded one does not.
  assign acc_ok = (int'(idx) < NACC);

  always_comb begin
    kind = TGT_NONE;
    if (en) begin
      if (acc)             kind = acc_ok ? TGT_ACC : TGT_NONE;
      else if (idx[IW-1])  kind = TGT_PERI;
      else                 kind = TGT_BANK;
    end
  end

endmodule

// File: rtl/rfv_accum.sv
module rfv_accum #(
  parameter  int LANES = 16,
  parameter  int DW    = 32,
  parameter  int NACC  = 4,
  localparam int VW    = LANES * DW,
  localparam int AW    = (NACC > 1) ? $clog2(NACC) : 1,
  localparam int CW    = $clog2(NACC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            we,
  input  logic [1:0][AW-1:0]    widx,
  input  logic [1:0][VW-1:0]    wdata,
  input  logic [1:0][LANES-1:0] wmask,
  input  logic                  r4_load,
  input  logic [VW-1:0]         r4_data,
  input  logic [1:0][CW-1:0]    rcode,
  output logic [1:0][VW-1:0]    rdata
);

  logic [VW-1:0]   acc_q   [NACC];
  logic [VW-1:0]   acc_nxt [NACC];
  logic [NACC-1:0] acc_en;
  logic [VW-1:0]   r4_q;

  for (genvar a = 0; a < NACC; a++) begin : g_acc
    logic hit0, hit1;
    assign hit0 = we[0] && (widx[0] == AW'(a));
    assign hit1 = we[1] && (widx[1] == AW'(a));
    assign acc_en[a] = hit0 | hit1;

    // Lane merge: multiply slot first, add slot on top.
    always_comb begin
      acc_nxt[a] = acc_q[a];
      for (int l = 0; l < LANES; l++) begin
        if (hit1 && wmask[1][l]) acc_nxt[a][l*DW +: DW] = wdata[1][l*DW +: DW];
        if (hit0 && wmask[0][l]) acc_nxt[a][l*DW +: DW] = wdata[0][l*DW +: DW];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc_q[a] <= '0;
      else if (acc_en[a])  acc_q[a] <= acc_nxt[a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       r4_q <= '0;
    else if (r4_load) r4_q <= r4_data;
  end

  // Reads take the next-state value so a same-cycle write is bypassed.
  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (int'(rcode[p]) < NACC)       rdata[p] = acc_nxt[rcode[p][AW-1:0]];
      else if (int'(rcode[p]) == NACC) rdata[p] = r4_q;
      else                             rdata[p] = '0;
    end
  end

endmodule

// File: rtl/rfv_bank.sv
module rfv_bank #(
  parameter  int LANES = 16,
  parameter  int DW    = 32,
  parameter  int DEPTH = 32,
  localparam int VW    = LANES * DW,
  localparam int BW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            we,
  input  logic [1:0][BW-1:0]    widx,
  input  logic [1:0][VW-1:0]    wdata,
  input  logic [1:0][LANES-1:0] wmask,
  input  logic                  re,
  input  logic [BW-1:0]         ridx,
  output logic [VW-1:0]         rdata,
  output logic                  hazard
);

  logic [VW-1:0]          mem [DEPTH];
  logic [1:0]             pend_v_q;
  logic [1:0][BW-1:0]     pend_idx_q;
  logic [1:0][VW-1:0]     pend_data_q;
  logic [1:0][LANES-1:0]  pend_mask_q;
  logic [1:0][VW-1:0]     commit_row;
  logic [1:0]             pend_match;

  // Write stage: one cycle between a slot write and the array update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v_q <= '0;
    else        pend_v_q <= we;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (we[s]) begin
        pend_idx_q[s]  <= widx[s];
        pend_data_q[s] <= wdata[s];
        pend_mask_q[s] <= wmask[s];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < LANES; l++) begin
        commit_row[s][l*DW +: DW] = pend_mask_q[s][l] ? pend_data_q[s][l*DW +: DW]
                                                      : mem[pend_idx_q[s]][l*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (pend_v_q[s]) mem[pend_idx_q[s]] <= commit_row[s];
    end
  end

  // Array read returns committed data only; a pending match is a hazard.
  assign rdata = mem[ridx];

  for (genvar s = 0; s < 2; s++) begin : g_match
    assign pend_match[s] = pend_v_q[s] && (pend_idx_q[s] == ridx);
  end

  assign hazard = re && (|pend_match);

endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
  import rfv_pkg::*;
#(
  parameter  int LANES = 16,
  parameter  int DW    = 32,
  parameter  int NACC  = 4,
  parameter  int DEPTH = 32,
  localparam int VW    = LANES * DW,
  localparam int BW    = $clog2(DEPTH),
  localparam int IW    = BW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wa_en,
  input  logic             wa_acc,
  input  logic             wa_bank,
  input  logic [IW-1:0]    wa_idx,
  input  logic [VW-1:0]    wa_data,
  input  logic [LANES-1:0] wa_mask,
  input  logic             wm_en,
  input  logic             wm_acc,
  input  logic             wm_bank,
  input  logic [IW-1:0]    wm_idx,
  input  logic [VW-1:0]    wm_data,
  input  logic [LANES-1:0] wm_mask,
  input  logic             r4_load,
  input  logic [VW-1:0]    r4_data,
  input  logic             rd0_en,
  input  logic             rd0_acc,
  input  logic [IW-1:0]    rd0_idx,
  output logic [VW-1:0]    rd0_data,
  input  logic             rd1_en,
  input  logic             rd1_acc,
  input  logic [IW-1:0]    rd1_idx,
  output logic [VW-1:0]    rd1_data,
  output logic             prd0_req,
  output logic [BW-1:0]    prd0_idx,
  input  logic [VW-1:0]    prd0_data,
  output logic             prd1_req,
  output logic [BW-1:0]    prd1_idx,
  input  logic [VW-1:0]    prd1_data,
  output logic             pw0_valid,
  output logic             pw0_bank,
  output logic [BW-1:0]    pw0_idx,
  output logic [VW-1:0]    pw0_data,
  output logic [LANES-1:0] pw0_mask,
  output logic             pw1_valid,
  output logic             pw1_bank,
  output logic [BW-1:0]    pw1_idx,
  output logic [VW-1:0]    pw1_data,
  output logic [LANES-1:0] pw1_mask,
  output logic             bank_hazard
);

  localparam int AW = (NACC > 1) ? $clog2(NACC) : 1;
  localparam int CW = $clog2(NACC + 1);

  // Slot bundles: index 0 = add slot, 1 = multiply slot.
  logic [1:0]            s_en, s_acc, s_bank;
  logic [1:0][IW-1:0]    s_idx;
  logic [1:0][VW-1:0]    s_data;
  logic [1:0][LANES-1:0] s_mask;
  tgt_e                  kind_raw [NUM_SLOTS];
  tgt_e                  kind     [NUM_SLOTS];
  logic                  clash;

  assign s_en   = {wm_en,   wa_en};
  assign s_acc  = {wm_acc,  wa_acc};
  assign s_bank = {wm_bank, wa_bank};
  assign s_idx  = {wm_idx,  wa_idx};
  assign s_data = {wm_data, wa_data};
  assign s_mask = {wm_mask, wa_mask};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
    rfv_slot_dec #(.IW(IW), .NACC(NACC)) u_dec (
      .en   (s_en[s]),
      .acc  (s_acc[s]),
      .idx  (s_idx[s]),
      .kind (kind_raw[s])
    );
  end

  // Same-target collision: add slot keeps its write, multiply slot is dropped.
  always_comb begin
    clash = (kind_raw[0] != TGT_NONE) && (kind_raw[0] == kind_raw[1]) &&
            (s_idx[0] == s_idx[1]) &&
            ((kind_raw[0] == TGT_ACC) || (s_bank[0] == s_bank[1]));
    kind[0] = kind_raw[0];
    kind[1] = clash ? TGT_NONE : kind_raw[1];
  end

  // Read port bundles: port 0 faces bank A, port 1 faces bank B.
  logic [1:0]         r_en, r_acc;
  logic [1:0][IW-1:0] r_idx;
  logic [1:0][VW-1:0] prd_in;
  logic [1:0][VW-1:0] rd_out;
  logic [1:0][VW-1:0] acc_rdata;
  logic [1:0][VW-1:0] bank_rdata;
  logic [1:0]         bank_haz;
  logic [1:0]         r_peri;
  logic [1:0][CW-1:0] r_code;

  assign r_en   = {rd1_en,   rd0_en};
  assign r_acc  = {rd1_acc,  rd0_acc};
  assign r_idx  = {rd1_idx,  rd0_idx};
  assign prd_in = {prd1_data, prd0_data};

  // Accumulators
  logic [1:0]         acc_we;
  logic [1:0][AW-1:0] acc_widx;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_accw
    assign acc_we[s]   = (kind[s] == TGT_ACC);
    assign acc_widx[s] = s_idx[s][AW-1:0];
  end

  for (genvar p = 0; p < 2; p++) begin : g_code
    // Codes outside the 3-bit accumulator field map to an unused code.
    assign r_code[p] = (r_idx[p][IW-1:CW] == '0) ? r_idx[p][CW-1:0] : CW'(NACC + 1);
  end

  rfv_accum #(.LANES(LANES), .DW(DW), .NACC(NACC)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (acc_we),
    .widx    (acc_widx),
    .wdata   (s_data),
    .wmask   (s_mask),
    .r4_load (r4_load),
    .r4_data (r4_data),
    .rcode   (r_code),
    .rdata   (acc_rdata)
  );

  // Banks
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [1:0]         b_we;
    logic [1:0][BW-1:0] b_widx;
    logic               b_re;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bw
      assign b_we[s]   = (kind[s] == TGT_BANK) && (s_bank[s] == 1'(g));
      assign b_widx[s] = s_idx[s][BW-1:0];
    end

    assign b_re = r_en[g] && !r_acc[g] && !r_idx[g][IW-1];

    rfv_bank #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (b_we),
      .widx   (b_widx),
      .wdata  (s_data),
      .wmask  (s_mask),
      .re     (b_re),
      .ridx   (r_idx[g][BW-1:0]),
      .rdata  (bank_rdata[g]),
      .hazard (bank_haz[g])
    );
  end

  // Read output select
  for (genvar p = 0; p < 2; p++) begin : g_rmux
    assign r_peri[p] = r_en[p] && !r_acc[p] && r_idx[p][IW-1];
    always_comb begin
      if (!r_en[p])       rd_out[p] = '0;
      else if (r_acc[p])  rd_out[p] = acc_rdata[p];
      else if (r_peri[p]) rd_out[p] = prd_in[p];
      else                rd_out[p] = bank_rdata[p];
    end
  end

  assign rd0_data = rd_out[0];
  assign rd1_data = rd_out[1];
  assign prd0_req = r_peri[0];
  assign prd1_req = r_peri[1];
  assign prd0_idx = rd0_idx[BW-1:0];
  assign prd1_idx = rd1_idx[BW-1:0];

  // Peripheral write side-channel
  assign pw0_valid = (kind[0] == TGT_PERI);
  assign pw0_bank  = wa_bank;
  assign pw0_idx   = wa_idx[BW-1:0];
  assign pw0_data  = wa_data;
  assign pw0_mask  = wa_mask;
  assign pw1_valid = (kind[1] == TGT_PERI);
  assign pw1_bank  = wm_bank;
  assign pw1_idx   = wm_idx[BW-1:0];
  assign pw1_data  = wm_data;
  assign pw1_mask  = wm_mask;

  // Sticky hazard flag
  logic haz_q, haz_nxt;

  always_comb haz_nxt = haz_q | (|bank_haz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) haz_q <= 1'b0;
    else        haz_q <= haz_nxt;
  end

  assign bank_hazard = haz_q;

endmodule

// File: rtl/lane_regfile_chk.sv
module lane_regfile_chk #(
  parameter  int LANES = 16,
  parameter  int DW    = 32,
  parameter  int NACC  = 4,
  parameter  int DEPTH = 32,
  localparam int VW    = LANES * DW,
  localparam int IW    = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wa_en,
  input logic             wa_acc,
  input logic             wa_bank,
  input logic [IW-1:0]    wa_idx,
  input logic [VW-1:0]    wa_data,
  input logic [LANES-1:0] wa_mask,
  input logic             wm_en,
  input logic             wm_acc,
  input logic             wm_bank,
  input logic [IW-1:0]    wm_idx,
  input logic             rd0_en,
  input logic             rd0_acc,
  input logic [IW-1:0]    rd0_idx,
  input logic [VW-1:0]    rd0_data,
  input logic             rd1_en,
  input logic [VW-1:0]    rd1_data,
  input logic             prd0_req,
  input logic [VW-1:0]    prd0_data,
  input logic             prd1_req,
  input logic [VW-1:0]    prd1_data,
  input logic             pw0_valid,
  input logic             pw1_valid,
  input logic             bank_hazard
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r5_hazard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hazard |=> bank_hazard);

  a_r5_hazard_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd0_en && !rd0_acc && !rd0_idx[IW-1] &&
     $past(wa_en && !wa_acc && !wa_bank && !wa_idx[IW-1]) &&
     ($past(wa_idx) == rd0_idx)) |=> bank_hazard);

  a_r3_acc_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_en && rd0_acc && wa_en && wa_acc && (wa_idx == rd0_idx) &&
     (int'(rd0_idx) < NACC) && (&wa_mask)) |-> (rd0_data == wa_data));

  a_r8_peri_read0: assert property (@(posedge clk) disable iff (!rst_n)
    prd0_req |-> (rd0_data == prd0_data));

  a_r8_peri_read1: assert property (@(posedge clk) disable iff (!rst_n)
    prd1_req |-> (rd1_data == prd1_data));

  a_r6_peri_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wm_en && !wa_acc && !wm_acc && wa_idx[IW-1] &&
     (wa_idx == wm_idx) && (wa_bank == wm_bank)) |-> (pw0_valid && !pw1_valid));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd1_en |-> (rd1_data == '0));

endmodule

bind lane_regfile lane_regfile_chk #(
  .LANES(LANES), .DW(DW), .NACC(NACC), .DEPTH(DEPTH)
) i_chk (.*);

// File: tb/test_lane_regfile.sv
`timescale 1ns/1ps
module test_lane_regfile;

  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int VW    = LANES * DW;

  logic clk = 1'b0;
  logic rst_n;
  logic wa_en, wa_acc, wa_bank; logic [5:0] wa_idx; logic [VW-1:0] wa_data; logic [3:0] wa_mask;
  logic wm_en, wm_acc, wm_bank; logic [5:0] wm_idx; logic [VW-1:0] wm_data; logic [3:0] wm_mask;
  logic r4_load; logic [VW-1:0] r4_data;
  logic rd0_en, rd0_acc; logic [5:0] rd0_idx; logic [VW-1:0] rd0_data;
  logic rd1_en, rd1_acc; logic [5:0] rd1_idx; logic [VW-1:0] rd1_data;
  logic prd0_req, prd1_req; logic [4:0] prd0_idx, prd1_idx; logic [VW-1:0] prd0_data, prd1_data;
  logic pw0_valid, pw0_bank, pw1_valid, pw1_bank; logic [4:0] pw0_idx, pw1_idx;
  logic [VW-1:0] pw0_data, pw1_data; logic [3:0] pw0_mask, pw1_mask;
  logic bank_hazard;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  lane_regfile #(.LANES(LANES), .DW(DW)) i_lane_regfile (.*);

  // Lane l of the vector carries v + l.
  function automatic logic [63:0] lv(input logic [15:0] v);
    logic [63:0] r;
    for (int l = 0; l < 4; l++) r[l*16 +: 16] = v + 16'(l);
    return r;
  endfunction

  typedef struct packed {
    logic wa_en, wa_acc, wa_bank; logic [5:0] wa_idx; logic [15:0] wa_v; logic [3:0] wa_m;
    logic wm_en, wm_acc, wm_bank; logic [5:0] wm_idx; logic [15:0] wm_v; logic [3:0] wm_m;
    logic r0_acc; logic [5:0] r0_idx; logic r1_acc; logic [5:0] r1_idx;
    logic [63:0] e0; logic [63:0] e1;
  } row_t;

  localparam logic [63:0] ACC1_PART = 64'h0000_0016_0000_0014;
  localparam logic [63:0] A5_MERGE  = 64'h012F_012E_0065_0064;
  localparam int NROWS = 11;

  localparam row_t TBL [NROWS] = '{
    '{1,0,0,6'd5,16'd100,4'hF, 1,0,1,6'd7,16'd200,4'hF, 1,6'd0, 1,6'd1, 64'd0,    64'd0},
    '{1,1,0,6'd0,16'd10,4'hF,  1,1,0,6'd1,16'd20,4'h5,  1,6'd0, 1,6'd1, lv(10),   ACC1_PART},
    '{0,0,0,6'd0,16'd0,4'h0,   0,0,0,6'd0,16'd0,4'h0,   0,6'd5, 0,6'd7, lv(100),  lv(200)},
    '{1,0,0,6'd5,16'd300,4'hC, 0,0,0,6'd0,16'd0,4'h0,   1,6'd1, 1,6'd0, ACC1_PART, lv(10)},
    '{1,1,0,6'd2,16'd40,4'hF,  1,1,0,6'd2,16'd50,4'hF,  1,6'd2, 1,6'd3, lv(40),   64'd0},
    '{0,0,0,6'd0,16'd0,4'h0,   0,0,0,6'd0,16'd0,4'h0,   0,6'd5, 0,6'd7, A5_MERGE, lv(200)},
    '{1,1,0,6'd4,16'd77,4'hF,  0,0,0,6'd0,16'd0,4'h0,   1,6'd4, 1,6'd2, 64'd0,    lv(40)},
    '{0,0,0,6'd0,16'd0,4'h0,   0,0,0,6'd0,16'd0,4'h0,   1,6'd4, 1,6'd5, 64'd0,    64'd0},
    '{1,0,1,6'd3,16'd500,4'hF, 1,0,1,6'd3,16'd600,4'hF, 1,6'd0, 1,6'd1, lv(10),   ACC1_PART},
    '{0,0,0,6'd0,16'd0,4'h0,   0,0,0,6'd0,16'd0,4'h0,   1,6'd2, 1,6'd3, lv(40),   64'd0},
    '{0,0,0,6'd0,16'd0,4'h0,   0,0,0,6'd0,16'd0,4'h0,   0,6'd5, 0,6'd3, A5_MERGE, lv(500)}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wa_en = 0; wa_acc = 0; wa_bank = 0; wa_idx = '0; wa_data = '0; wa_mask = '0;
    wm_en = 0; wm_acc = 0; wm_bank = 0; wm_idx = '0; wm_data = '0; wm_mask = '0;
    r4_load = 0; r4_data = '0;
    rd0_en = 0; rd0_acc = 0; rd0_idx = '0; rd1_en = 0; rd1_acc = 0; rd1_idx = '0;
    prd0_data = '0; prd1_data = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 hazard low in reset", 64'(bank_hazard), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: one row per cycle, outputs sampled mid-cycle.
    for (int i = 0; i < NROWS; i++) begin
      cyc();
      wa_en = TBL[i].wa_en; wa_acc = TBL[i].wa_acc; wa_bank = TBL[i].wa_bank;
      wa_idx = TBL[i].wa_idx; wa_data = lv(TBL[i].wa_v); wa_mask = TBL[i].wa_m;
      wm_en = TBL[i].wm_en; wm_acc = TBL[i].wm_acc; wm_bank = TBL[i].wm_bank;
      wm_idx = TBL[i].wm_idx; wm_data = lv(TBL[i].wm_v); wm_mask = TBL[i].wm_m;
      rd0_en = 1; rd0_acc = TBL[i].r0_acc; rd0_idx = TBL[i].r0_idx;
      rd1_en = 1; rd1_acc = TBL[i].r1_acc; rd1_idx = TBL[i].r1_idx;
      #1;
      chk($sformatf("R1/R2/R3/R4/R6/R7 row %0d port0", i), rd0_data, TBL[i].e0);
      chk($sformatf("R1/R2/R3/R4/R6/R7 row %0d port1", i), rd1_data, TBL[i].e1);
    end
    cyc(); #1;
    chk("R5 no hazard after spaced accesses", 64'(bank_hazard), 64'd0);

    // R5: different index in next cycle does not set the flag.
    cyc(); wa_en = 1; wa_idx = 6'd12; wa_data = lv(800); wa_mask = 4'hF;
    cyc(); rd0_en = 1; rd0_idx = 6'd13;
    cyc(); #1;
    chk("R5 other index no hazard", 64'(bank_hazard), 64'd0);
    // R4/R5: same index in next cycle is stale and flagged.
    cyc(); wa_en = 1; wa_idx = 6'd12; wa_data = lv(900); wa_mask = 4'hF;
    cyc(); rd0_en = 1; rd0_idx = 6'd12; #1;
    chk("R4 stale read right after write", rd0_data, lv(800));
    chk("R5 flag not yet raised", 64'(bank_hazard), 64'd0);
    cyc(); rd0_en = 1; rd0_idx = 6'd12; #1;
    chk("R4 new value two cycles later", rd0_data, lv(900));
    chk("R5 hazard raised", 64'(bank_hazard), 64'd1);
    repeat (3) cyc();
    #1;
    chk("R5 hazard sticky", 64'(bank_hazard), 64'd1);

    // R7: peripheral load of code 4, no same-cycle bypass.
    cyc(); r4_load = 1; r4_data = lv(55); rd0_en = 1; rd0_acc = 1; rd0_idx = 6'd4; #1;
    chk("R7 r4 old value in load cycle", rd0_data, 64'd0);
    cyc(); rd0_en = 1; rd0_acc = 1; rd0_idx = 6'd4; #1;
    chk("R7 r4 loaded value", rd0_data, lv(55));

    // R8: peripheral reads on both ports.
    cyc(); rd0_en = 1; rd0_idx = 6'd40; prd0_data = 64'hDEAD_BEEF_1234_5678;
    rd1_en = 1; rd1_idx = 6'd63; prd1_data = 64'h0BAD_F00D_0000_0001; #1;
    chk("R8 port0 request", 64'(prd0_req), 64'd1);
    chk("R8 port0 index", 64'(prd0_idx), 64'd8);
    chk("R8 port0 data", rd0_data, 64'hDEAD_BEEF_1234_5678);
    chk("R8 port1 index", 64'(prd1_idx), 64'd31);
    chk("R8 port1 data", rd1_data, 64'h0BAD_F00D_0000_0001);

    // R9: peripheral write leaves bank B register 1 untouched.
    cyc(); wm_en = 1; wm_bank = 1; wm_idx = 6'd1; wm_data = lv(1000); wm_mask = 4'hF;
    cyc();
    cyc(); wa_en = 1; wa_bank = 1; wa_idx = 6'd33; wa_data = lv(7); wa_mask = 4'hA; #1;
    chk("R9 pw0 valid", 64'(pw0_valid), 64'd1);
    chk("R9 pw0 bank/index", {pw0_bank, pw0_idx}, {58'd0, 1'b1, 5'd1});
    chk("R9 pw0 data", pw0_data, lv(7));
    chk("R9 pw0 mask", 64'(pw0_mask), 64'hA);
    chk("R9 pw1 idle", 64'(pw1_valid), 64'd0);
    cyc();
    cyc(); rd1_en = 1; rd1_idx = 6'd1; #1;
    chk("R9 bank B[1] unchanged", rd1_data, lv(1000));

    // R6: peripheral collision, then distinct targets.
    cyc(); wa_en = 1; wa_idx = 6'd50; wa_data = lv(11); wa_mask = 4'hF;
    wm_en = 1; wm_idx = 6'd50; wm_data = lv(22); wm_mask = 4'hF; #1;
    chk("R6 add slot peripheral kept", 64'(pw0_valid), 64'd1);
    chk("R6 mul slot peripheral dropped", 64'(pw1_valid), 64'd0);
    cyc(); wa_en = 1; wa_idx = 6'd50; wa_data = lv(11); wa_mask = 4'hF;
    wm_en = 1; wm_idx = 6'd51; wm_data = lv(22); wm_mask = 4'hF; #1;
    chk("R6 distinct peripheral both valid", {pw0_valid, pw1_valid}, 64'd3);
    chk("R9 pw1 index", 64'(pw1_idx), 64'd19);

    // R10: disabled port outputs zero although r0 holds data.
    cyc(); rd0_en = 0; rd0_acc = 1; rd0_idx = 6'd0; #1;
    chk("R10 disabled port zero", rd0_data, 64'd0);

    // R1: second reset clears the flag and the accumulators.
    cyc(); rst_n = 1'b0; #1;
    chk("R1 hazard cleared by reset", 64'(bank_hazard), 64'd0);
    cyc(); rst_n = 1'b1;
    cyc(); rd0_en = 1; rd0_acc = 1; rd0_idx = 6'd0; rd1_en = 1; rd1_acc = 1; rd1_idx = 6'd4; #1;
    chk("R1 r0 zero after reset", rd0_data, 64'd0);
    chk("R1 r4 zero after reset", rd1_data, 64'd0);

    cyc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule